// File: doc/BRIEF.md
# Priority-Masked Interrupt Controller

This block gathers interrupt requests from a set of sources and presents one request line to the CPU. Each source has its own 3-bit urgency level, where smaller numbers are more urgent. Each source also has a trigger mode, either held or latched. A sequencer walks the sources one per cycle and keeps the most urgent pending one whose level is below the current mask. At the end of each walk it publishes the winner and drives the CPU line from that result. The sequencer then starts the next walk at once, so changes at the sources are picked up without any software action.

Software reaches the block through a small register bus. The bus gives access to the mask, one configuration register per source and the vector register. Taking the vector hands back the winner's index and lowers the mask to the winner's level, so only more urgent sources can interrupt the handler. A write to the mask drops the CPU line at once and restarts the walk. Register offsets are parameters: the mask defaults to address 0, the vector to address 1 and source `i` to address 16+i.

Sequencer states: `SCAN_IDLE` is the single cycle after reset. `SCAN_WALK` evaluates one source per cycle. `SCAN_COMMIT` publishes the result. The transitions are:
- `SCAN_IDLE` to `SCAN_WALK`, unconditionally.
- `SCAN_WALK` to `SCAN_WALK` while sources remain.
- `SCAN_WALK` to `SCAN_COMMIT` after the last source.
- `SCAN_COMMIT` to `SCAN_WALK` to begin the next pass.
- Any state to `SCAN_WALK` at index 0 on a restart, which is a mask write or a vector take.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the mask reads 0x07, every source configuration reads 0x07 (level 7, held mode), the vector reads 0x00 and `cpu_irq` is low.
- R2: The mask occupies bits [2:0] of its register; writes to bits [7:3] are dropped and those bits read 0.
- R3: A source can raise `cpu_irq` only if it is pending and its level is strictly below the mask; a mask of 0 blocks everything, and level 7 is never accepted.
- R4: Any write to the mask clears `cpu_irq` on the next edge. The line stays low for the following NSRC cycles of the new pass, and is set on the edge after those if a source qualifies.
- R5: Among qualifying sources the lowest level wins; on equal levels the lower source index wins.
- R6: The vector read data carries the winner's index in bits [IDXW-1:0] and a valid flag in bit 7, with all other bits 0; it reads 0x00 when `cpu_irq` is low.
- R7: A vector read while `cpu_irq` is high loads the winner's level into the mask, clears `cpu_irq` on that edge and restarts the pass.
- R8: In latched mode (configuration bit 7 = 1) a source becomes pending on a rising edge of its input and stays pending until a vector read takes it. In held mode (bit 7 = 0) it is pending exactly while its input is high. Configuration bits [2:0] hold the level.
- R9: A vector read while `cpu_irq` is low leaves the mask unchanged.
- R10: Without any bus access, a newly pending qualifying source raises `cpu_irq` within 2×(NSRC+1) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | NSRC | Raw request from each source |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe; vector side effects apply at the edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| cpu_irq | output | 1 | Interrupt request to the CPU |

## Verification
The bench sweeps every pair of mask and level for a single held source. In that sweep it samples `cpu_irq` one cycle before the end of the pass and one cycle after it. A design that left the line high across a mask write, or that compared with `<=` instead of `<`, would fail at those points, and a design that accepted level 7 would fail at mask 7. Equal-level sources are set up so that a scan keeping the last equal candidate reports the wrong index. A vector take is followed by a mask readback, so a design that forgot the hardware mask load fails there. A latched source is taken and then rescanned, which exposes a pending flag that never clears. A vector read with nothing pending must leave the mask untouched.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int unsigned LVL_W = 3;

    typedef logic [LVL_W-1:0] lvl_t;

    localparam lvl_t LVL_OFF   = '1;
    localparam lvl_t MASK_INIT = '1;

    typedef enum logic [1:0] {
        SCAN_IDLE   = 2'd0,
        SCAN_WALK   = 2'd1,
        SCAN_COMMIT = 2'd2
    } scan_state_e;

endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
    import irq_pkg::*;
#(
    parameter int unsigned NSRC = 8,
    parameter int unsigned IDXW = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NSRC-1:0]       src_req,
    input  logic                  cfg_we,
    input  logic [IDXW-1:0]       cfg_sel,
    input  lvl_t                  cfg_wlvl,
    input  logic                  cfg_wmode,
    input  logic                  clr_en,
    input  logic [IDXW-1:0]       clr_idx,
    output logic [NSRC*LVL_W-1:0] lvl_flat,
    output logic [NSRC-1:0]       mode_vec,
    output logic [NSRC-1:0]       pend_vec
);

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        lvl_t lvl_q;
        logic mode_q;
        logic req_d;
        logic latch_q;
        logic rise;
        logic hit_cfg;
        logic hit_clr;

        assign hit_cfg = cfg_we && (cfg_sel == IDXW'(g));
        assign hit_clr = clr_en && (clr_idx == IDXW'(g));
        assign rise    = src_req[g] && !req_d;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lvl_q  <= LVL_OFF;
                mode_q <= 1'b0;
            end else if (hit_cfg) begin
                lvl_q  <= cfg_wlvl;
                mode_q <= cfg_wmode;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                req_d   <= 1'b0;
                latch_q <= 1'b0;
            end else begin
                req_d <= src_req[g];
                if (!mode_q)
                    latch_q <= 1'b0;
                else if (rise)
                    latch_q <= 1'b1;
                else if (hit_clr)
                    latch_q <= 1'b0;
            end
        end

        assign lvl_flat[g*LVL_W +: LVL_W] = lvl_q;
        assign mode_vec[g]                = mode_q;
        assign pend_vec[g]                = mode_q ? latch_q : src_req[g];
    end

endmodule

// File: rtl/irq_scan_fsm.sv
module irq_scan_fsm
    import irq_pkg::*;
#(
    parameter int unsigned NSRC = 8,
    parameter int unsigned IDXW = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  restart,
    input  lvl_t                  mask,
    input  logic [NSRC-1:0]       pend_vec,
    input  logic [NSRC*LVL_W-1:0] lvl_flat,
    output logic                  irq,
    output logic [IDXW-1:0]       win_idx,
    output lvl_t                  win_lvl
);

    localparam logic [IDXW-1:0] LAST = IDXW'(NSRC - 1);

    scan_state_e     state_q;
    scan_state_e     state_d;
    logic [IDXW-1:0] idx_q;
    logic            best_vld_q;
    logic [IDXW-1:0] best_idx_q;
    lvl_t            best_lvl_q;
    lvl_t            cand_lvl;
    logic            cand_ok;

    assign cand_lvl = lvl_flat[idx_q*LVL_W +: LVL_W];
    assign cand_ok  = pend_vec[idx_q]
                   && (cand_lvl < mask)
                   && (!best_vld_q || (cand_lvl < best_lvl_q));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SCAN_IDLE:   state_d = SCAN_WALK;
            SCAN_WALK:   state_d = (idx_q == LAST) ? SCAN_COMMIT : SCAN_WALK;
            SCAN_COMMIT: state_d = SCAN_WALK;
            default:     state_d = SCAN_IDLE;
        endcase
        if (restart)
            state_d = SCAN_WALK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SCAN_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q      <= '0;
            best_vld_q <= 1'b0;
            best_idx_q <= '0;
            best_lvl_q <= LVL_OFF;
        end else if (restart || state_q != SCAN_WALK) begin
            idx_q      <= '0;
            best_vld_q <= 1'b0;
            best_idx_q <= '0;
            best_lvl_q <= LVL_OFF;
        end else begin
            if (idx_q != LAST)
                idx_q <= idx_q + 1'b1;
            if (cand_ok) begin
                best_vld_q <= 1'b1;
                best_idx_q <= idx_q;
                best_lvl_q <= cand_lvl;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq     <= 1'b0;
            win_idx <= '0;
            win_lvl <= LVL_OFF;
        end else if (restart) begin
            irq <= 1'b0;
        end else if (state_q == SCAN_COMMIT) begin
            irq     <= best_vld_q;
            win_idx <= best_idx_q;
            win_lvl <= best_lvl_q;
        end
    end

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
#(
    parameter int unsigned NSRC      = 8,
    parameter int unsigned ADDR_W    = 6,
    parameter int unsigned MASK_ADDR = 0,
    parameter int unsigned VEC_ADDR  = 1,
    parameter int unsigned CFG_BASE  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_req,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              cpu_irq
);

    localparam int unsigned IDXW = $clog2(NSRC);
    localparam int unsigned PADW = 7 - IDXW;

    logic                  is_mask;
    logic                  is_vec;
    logic                  is_cfg;
    logic [ADDR_W-1:0]     cfg_off;
    logic [IDXW-1:0]       cfg_sel;
    logic                  mask_wr;
    logic                  vec_take;
    logic                  restart;
    lvl_t                  mask_q;
    lvl_t                  win_lvl;
    logic [IDXW-1:0]       win_idx;
    logic [NSRC*LVL_W-1:0] lvl_flat;
    logic [NSRC-1:0]       mode_vec;
    logic [NSRC-1:0]       pend_vec;
    lvl_t                  sel_lvl;

    assign is_mask  = (bus_addr == ADDR_W'(MASK_ADDR));
    assign is_vec   = (bus_addr == ADDR_W'(VEC_ADDR));
    assign is_cfg   = (bus_addr >= ADDR_W'(CFG_BASE))
                   && (bus_addr <  ADDR_W'(CFG_BASE + NSRC));
    assign cfg_off  = bus_addr - ADDR_W'(CFG_BASE);
    assign cfg_sel  = cfg_off[IDXW-1:0];

    assign mask_wr  = bus_wr && is_mask;
    assign vec_take = bus_rd && is_vec && cpu_irq;
    assign restart  = mask_wr || vec_take;

    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= MASK_INIT;
        else if (mask_wr)
            mask_q <= bus_wdata[LVL_W-1:0];
        else if (vec_take)
            mask_q <= win_lvl;
    end

    irq_src_bank #(
        .NSRC (NSRC),
        .IDXW (IDXW)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_req   (src_req),
        .cfg_we    (bus_wr && is_cfg),
        .cfg_sel   (cfg_sel),
        .cfg_wlvl  (bus_wdata[LVL_W-1:0]),
        .cfg_wmode (bus_wdata[7]),
        .clr_en    (vec_take),
        .clr_idx   (win_idx),
        .lvl_flat  (lvl_flat),
        .mode_vec  (mode_vec),
        .pend_vec  (pend_vec)
    );

    irq_scan_fsm #(
        .NSRC (NSRC),
        .IDXW (IDXW)
    ) u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .mask     (mask_q),
        .pend_vec (pend_vec),
        .lvl_flat (lvl_flat),
        .irq      (cpu_irq),
        .win_idx  (win_idx),
        .win_lvl  (win_lvl)
    );

    assign sel_lvl = lvl_flat[cfg_sel*LVL_W +: LVL_W];

    always_comb begin
        bus_rdata = 8'h00;
        if (is_mask)
            bus_rdata = {{(8-LVL_W){1'b0}}, mask_q};
        else if (is_vec)
            bus_rdata = cpu_irq ? {1'b1, {PADW{1'b0}}, win_idx} : 8'h00;
        else if (is_cfg)
            bus_rdata = {mode_vec[cfg_sel], {(7-LVL_W){1'b0}}, sel_lvl};
    end

endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
    parameter int unsigned ADDR_W    = 6,
    parameter int unsigned MASK_ADDR = 0,
    parameter int unsigned VEC_ADDR  = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [7:0]        bus_rdata,
    input logic              cpu_irq,
    input logic [2:0]        mask_q,
    input logic [2:0]        win_lvl
);

    logic at_mask;
    logic at_vec;

    assign at_mask = (bus_addr == ADDR_W'(MASK_ADDR));
    assign at_vec  = (bus_addr == ADDR_W'(VEC_ADDR));

    assert_mask_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        at_mask |-> (bus_rdata[7:3] == 5'd0));

    assert_irq_below_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> (win_lvl < mask_q));

    assert_level7_never_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> (win_lvl != 3'd7));

    assert_irq_drop_on_mask_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at_mask) |=> !cpu_irq);

    assert_vector_loads_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && at_vec && bus_rdata[7]) |=> ((mask_q == $past(win_lvl)) && !cpu_irq));

    assert_empty_vector_keeps_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && at_vec && !bus_rdata[7]) |=> $stable(mask_q));

endmodule

bind irq_ctrl irq_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .MASK_ADDR (MASK_ADDR),
    .VEC_ADDR  (VEC_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .cpu_irq   (cpu_irq),
    .mask_q    (mask_q),
    .win_lvl   (win_lvl)
);

// File: tb/sim_irq_ctrl.sv
`timescale 1ns/1ps
module sim_irq_ctrl;

    localparam int NSRC   = 8;
    localparam int ADDR_W = 6;
    localparam int PASS   = NSRC + 1;
    localparam logic [ADDR_W-1:0] A_MASK = 6'd0;
    localparam logic [ADDR_W-1:0] A_VEC  = 6'd1;
    localparam logic [ADDR_W-1:0] A_CFG  = 6'd16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC-1:0]   src_req = '0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [7:0]        bus_wdata = '0;
    logic [7:0]        bus_rdata;
    logic              cpu_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    irq_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_req   (src_req),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cpu_irq   (cpu_irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_pass();
        repeat (PASS) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_sources();
        src_req = '0;
        for (int i = 0; i < NSRC; i++) wr(A_CFG + ADDR_W'(i), 8'h07);
        wr(A_MASK, 8'h07);
        wait_pass();
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 irq after reset", int'(cpu_irq), 0);
        rd(A_MASK, d);  check("R1 mask after reset", d, 8'h07);
        rd(A_CFG + 6'd3, d); check("R1 cfg after reset", d, 8'h07);
        rd(A_VEC, d);   check("R1 vector after reset", d, 8'h00);
    endtask

    task automatic t_mask_field();
        logic [7:0] d;
        wr(A_MASK, 8'hFD);
        rd(A_MASK, d); check("R2 mask upper bits", d, 8'h05);
        wr(A_MASK, 8'h07);
        wait_pass();
    endtask

    task automatic t_gating_sweep();
        src_req[0] = 1'b1;
        for (int lv = 0; lv < 8; lv++) begin
            for (int mk = 0; mk < 8; mk++) begin
                wr(A_CFG, 8'(lv));
                wr(A_MASK, 8'(mk));
                repeat (NSRC) @(posedge clk);
                @(negedge clk);
                check($sformatf("R4 low during pass m%0d l%0d", mk, lv), int'(cpu_irq), 0);
                @(posedge clk);
                @(negedge clk);
                check($sformatf("R3 gate m%0d l%0d", mk, lv), int'(cpu_irq), (lv < mk) ? 1 : 0);
            end
        end
        clear_sources();
    endtask

    task automatic t_priority_and_take();
        logic [7:0] d;
        wr(A_CFG + 6'd1, 8'h03);
        wr(A_CFG + 6'd2, 8'h01);
        wr(A_CFG + 6'd5, 8'h01);
        src_req = 8'b0010_0110;
        wr(A_MASK, 8'h07);
        wait_pass();
        check("R5 irq with winners", int'(cpu_irq), 1);
        rd(A_VEC, d); check("R5 R6 vector tie to lower index", d, 8'h82);
        check("R7 irq drops on take", int'(cpu_irq), 0);
        rd(A_MASK, d); check("R7 mask loaded from winner", d, 8'h01);
        wait_pass();
        check("R7 nothing below new mask", int'(cpu_irq), 0);
        wr(A_CFG + 6'd6, 8'h00);
        src_req[6] = 1'b1;
        wr(A_MASK, 8'h07);
        wait_pass();
        rd(A_VEC, d); check("R5 lowest level wins", d, 8'h86);
        clear_sources();
    endtask

    task automatic t_empty_vector();
        logic [7:0] d;
        src_req[2] = 1'b1;
        wr(A_CFG + 6'd2, 8'h00);
        wr(A_MASK, 8'h00);
        wait_pass();
        check("R3 mask zero blocks", int'(cpu_irq), 0);
        rd(A_VEC, d);  check("R6 vector empty", d, 8'h00);
        rd(A_MASK, d); check("R9 mask unchanged", d, 8'h00);
        clear_sources();
    endtask

    task automatic t_latched_mode();
        logic [7:0] d;
        wr(A_CFG + 6'd3, 8'h82);
        rd(A_CFG + 6'd3, d); check("R8 cfg readback", d, 8'h82);
        @(negedge clk); src_req[3] = 1'b1;
        @(negedge clk); src_req[3] = 1'b0;
        wr(A_MASK, 8'h07);
        wait_pass();
        check("R8 latched pending after pulse", int'(cpu_irq), 1);
        rd(A_VEC, d);  check("R8 vector latched", d, 8'h83);
        rd(A_MASK, d); check("R7 mask after latched take", d, 8'h02);
        wr(A_MASK, 8'h07);
        wait_pass();
        check("R8 latched cleared by take", int'(cpu_irq), 0);
        wr(A_CFG + 6'd3, 8'h02);
        src_req[3] = 1'b1;
        wr(A_MASK, 8'h07);
        wait_pass();
        rd(A_VEC, d); check("R8 held vector", d, 8'h83);
        wr(A_MASK, 8'h07);
        wait_pass();
        check("R8 held source persists", int'(cpu_irq), 1);
        clear_sources();
    endtask

    task automatic t_free_running();
        logic [7:0] d;
        wr(A_CFG + 6'd4, 8'h00);
        repeat (3) @(negedge clk);
        check("R10 idle before request", int'(cpu_irq), 0);
        src_req[4] = 1'b1;
        repeat (2 * PASS) @(posedge clk);
        @(negedge clk);
        check("R10 picked up without write", int'(cpu_irq), 1);
        rd(A_VEC, d); check("R10 vector", d, 8'h84);
        clear_sources();
    endtask

    initial begin
        #(150000 * 10);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mask_field();
        t_gating_sweep();
        t_priority_and_take();
        t_empty_vector();
        t_latched_mode();
        t_free_running();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule